// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit linear address into a physical page frame by reading a four-level hierarchy of 64-bit translation entries from memory. A single-cycle start pulse supplies the linear address, the page-aligned root table base, and the access attributes: write, user mode, write-protect enable and instruction fetch. The walker then issues one read per level on a valid/ready memory port with at most one access outstanding. It waits for the response, checks the entry, and either descends to the next table or stops at a leaf.

Each entry is checked for presence and for reserved bits, and its read/write and user/supervisor rights are folded into a running access value. A page-size bit on the third level ends the walk with a 1 GB page, and on the second level with a 2 MB page. Otherwise the walk ends at the fourth read with a 4 KB page. At the leaf, the folded rights go through a single permission check. If the access is allowed but the leaf's accessed flag is clear, or the access is a write and its dirty flag is clear, the walker writes the updated entry back to the address it was read from. It then reports the frame and the page offset mask. Any failure reports a page-fault error code instead.

Top module: `pt_walker`

## Requirements
- R1: Reads go to levels 3, 2, 1, 0 in that order. The read address at level L is {table base, linear address bits [12+9L+8:12+9L], 3'b000}, and the first table base is i_root.
- R2: A valid entry that is not a leaf supplies the next table base from its bits [PA_W-1:12].
- R3: An entry with bit 0 clear ends the walk with a fault. The error code is {bit3=0, bit2=user, bit1=write, bit0=0}, and no further access follows.
- R4: An entry has a reserved-bit fault if any of these holds: any of bits [51:PA_W] is set, bit 7 is set at level 3, bit 7 is set at level 2 with 1 GB pages disabled, bit 7 is set at level 2 and any of bits [29:13] is set, or bit 7 is set at level 1 and any of bits [20:13] is set. This fault has error code {1, user, write, 1}.
- R5: Bit 7 set at level 2 yields a 1 GB page. The frame is {entry[PA_W-1:30], la[29:12]} and the mask is 0x3FFFFFFF.
- R6: Bit 7 set at level 1 yields a 2 MB page. The frame is {entry[PA_W-1:21], la[20:12]} and the mask is 0x1FFFFF.
- R7: A level 0 leaf yields a 4 KB page. The frame is entry[PA_W-1:12] and the mask is 0xFFF.
- R8: Bit 1 (writable) and bit 2 (user) are ANDed over every level visited. A user access needs the combined user bit, and a user write also needs the combined writable bit. A supervisor write to a non-writable page is allowed only when write-protect is 0. A denial faults with {0, user, write, 1}.
- R9: A fetch through any entry with bit 63 set faults with {0, user, write, 1}.
- R10: On an allowed leaf, if bit 5 is clear, or the access is a write and bit 6 is clear, exactly one write of entry|bit5|(write?bit6:0) goes to the leaf address before done. No write occurs otherwise.
- R11: After reset both done and fault are low. Each result is a one-cycle pulse of done or fault, never both. A start pulse while a walk is in progress is ignored.
- R12: A request holds its valid, address and write flag stable until it is accepted, and no new request is issued before the response to a read arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | Start pulse, taken only when idle |
| i_laddr | input | LA_W | Linear address to translate |
| i_root | input | PA_W-12 | Root table base, page number |
| i_write | input | 1 | Access is a write |
| i_user | input | 1 | Access is from user mode |
| i_wp | input | 1 | Write-protect enable for supervisor writes |
| i_fetch | input | 1 | Access is an instruction fetch |
| o_req_valid | output | 1 | Memory request valid |
| i_req_ready | input | 1 | Memory request accepted |
| o_req_write | output | 1 | Request is an entry write-back |
| o_req_addr | output | PA_W | Entry byte address |
| o_req_wdata | output | 64 | Write-back data |
| i_rsp_valid | input | 1 | Read data valid |
| i_rsp_data | input | 64 | Read data |
| o_done | output | 1 | Successful translation pulse |
| o_fault | output | 1 | Page fault pulse |
| o_pfn | output | PA_W-12 | Resulting physical frame number |
| o_mask | output | 30 | Page offset mask |
| o_err | output | 4 | Fault error code |

## Verification
Several hundred random walks are built in a sparse memory model. Each walk picks a leaf level, random linear and root addresses, random rights, a random no-execute bit, and random accessed and dirty bits. Some walks also carry deliberate damage: a cleared present bit, a high reserved bit, a stray page-size bit, or a low frame bit under a large page. Clean walks separate the three page sizes and the frame splicing, and they show whether the read address sequence follows each level's base. Random attribute mixes separate user from supervisor and write-protect on or off, and show which combinations need a write-back. Directed walks check that no write-back occurs when both flags are already set, and that a second start in the middle of a walk has no effect. Random ready and latency delays on the memory port test that requests are held until accepted.

// File: rtl/pw_pkg.sv
package pw_pkg;

  localparam int ENT_W    = 64;
  localparam int IDX_W    = 9;
  localparam int PG_SHIFT = 12;
  localparam int B_PRES   = 0;
  localparam int B_RW     = 1;
  localparam int B_US     = 2;
  localparam int B_ACC    = 5;
  localparam int B_DIRTY  = 6;
  localparam int B_PS     = 7;
  localparam int B_XD     = 63;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WB_REQ
  } walk_state_e;

  typedef struct packed {
    logic rsvd;
    logic user;
    logic wr;
    logic prot;
  } pf_code_t;

  // Table index of one level: nine linear address bits above the page offset.
  function automatic logic [IDX_W-1:0] lvl_index(input logic [63:0] la, input logic [1:0] lvl);
    logic [63:0] sh;
    sh = la >> (PG_SHIFT + IDX_W * int'(lvl));
    return sh[IDX_W-1:0];
  endfunction

  // Permission decision on the key {wp, user, us, rw, write}.
  function automatic logic rights_ok(input logic [4:0] key);
    if (key[3]) return key[2] && (!key[0] || key[1]);
    return !key[0] || key[1] || !key[4];
  endfunction

  function automatic pf_code_t make_code(input logic rsvd, input logic prot,
                                         input logic user, input logic wr);
    pf_code_t c;
    c.rsvd = rsvd;
    c.user = user;
    c.wr   = wr;
    c.prot = prot;
    return c;
  endfunction

endpackage

// File: rtl/pw_entry_decode.sv
module pw_entry_decode import pw_pkg::*; #(
  parameter int PA_W  = 40,
  parameter bit EN_1G = 1'b1,
  localparam int FN_W = PA_W - PG_SHIFT
) (
  input  logic [ENT_W-1:0] i_entry,
  input  logic [1:0]       i_lvl,
  input  logic [17:0]      i_la_mid,
  output logic             o_absent,
  output logic             o_rsvd,
  output logic             o_leaf,
  output logic [FN_W-1:0]  o_pfn,
  output logic [FN_W-1:0]  o_next,
  output logic [29:0]      o_mask
);

  logic ps, hi_rsvd, lvl_top, lvl_dpt, lvl_dir, lvl_tab;
  logic gig_low, meg_low;
  logic unused_bits;

  assign ps      = i_entry[B_PS];
  assign lvl_top = (i_lvl == 2'd3);
  assign lvl_dpt = (i_lvl == 2'd2);
  assign lvl_dir = (i_lvl == 2'd1);
  assign lvl_tab = (i_lvl == 2'd0);
  assign gig_low = |i_entry[29:13];
  assign meg_low = |i_entry[20:13];

  generate
    if (PA_W < 52) begin : g_hi
      assign hi_rsvd = |i_entry[51:PA_W];
    end else begin : g_nohi
      assign hi_rsvd = 1'b0;
    end
  endgenerate

  assign o_absent = ~i_entry[B_PRES];
  assign o_rsvd   = hi_rsvd
                  | (lvl_top & ps)
                  | (lvl_dpt & ps & (~EN_1G | gig_low))
                  | (lvl_dir & ps & meg_low);
  assign o_leaf   = lvl_tab | (lvl_dir & ps) | (lvl_dpt & ps & EN_1G);
  assign o_next   = i_entry[PA_W-1:PG_SHIFT];

  always_comb begin
    case (i_lvl)
      2'd2: begin
        o_pfn  = {i_entry[PA_W-1:30], i_la_mid};
        o_mask = 30'h3FFF_FFFF;
      end
      2'd1: begin
        o_pfn  = {i_entry[PA_W-1:21], i_la_mid[8:0]};
        o_mask = 30'h001F_FFFF;
      end
      default: begin
        o_pfn  = i_entry[PA_W-1:PG_SHIFT];
        o_mask = 30'h0000_0FFF;
      end
    endcase
  end

  assign unused_bits = ^{i_entry[63:52], i_entry[11:8], i_entry[6:1]};

endmodule

// File: rtl/pw_rights.sv
module pw_rights import pw_pkg::*; (
  input  logic [1:0] i_acc_prev,
  input  logic       i_ent_us,
  input  logic       i_ent_rw,
  input  logic       i_nx_prev,
  input  logic       i_ent_xd,
  input  logic       i_fetch,
  input  logic       i_wp,
  input  logic       i_user,
  input  logic       i_write,
  output logic [1:0] o_acc,
  output logic       o_nx,
  output logic       o_allow
);

  // o_acc[1] is the folded user bit, o_acc[0] the folded writable bit.
  assign o_acc   = i_acc_prev & {i_ent_us, i_ent_rw};
  assign o_nx    = i_nx_prev | (i_fetch & i_ent_xd);
  assign o_allow = rights_ok({i_wp, i_user, o_acc[1], o_acc[0], i_write}) & ~o_nx;

endmodule

// File: rtl/pt_walker.sv
module pt_walker import pw_pkg::*; #(
  parameter int LA_W  = 48,
  parameter int PA_W  = 40,
  parameter bit EN_1G = 1'b1,
  localparam int FN_W = PA_W - PG_SHIFT,
  localparam int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_start,
  input  logic [LA_W-1:0]  i_laddr,
  input  logic [FN_W-1:0]  i_root,
  input  logic             i_write,
  input  logic             i_user,
  input  logic             i_wp,
  input  logic             i_fetch,
  output logic             o_req_valid,
  input  logic             i_req_ready,
  output logic             o_req_write,
  output logic [PA_W-1:0]  o_req_addr,
  output logic [ENT_W-1:0] o_req_wdata,
  input  logic             i_rsp_valid,
  input  logic [ENT_W-1:0] i_rsp_data,
  output logic             o_done,
  output logic             o_fault,
  output logic [FN_W-1:0]  o_pfn,
  output logic [29:0]      o_mask,
  output logic [3:0]       o_err
);

  walk_state_e      st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [LA_W-1:0]  la_q;
  logic             wr_q, user_q, wp_q, fetch_q;
  logic [FN_W-1:0]  base_q;
  logic [1:0]       acc_q;
  logic             nx_q;
  logic [ENT_W-1:0] wb_data_q;
  logic             done_q, fault_q;
  logic [FN_W-1:0]  pfn_q;
  logic [29:0]      mask_q;
  pf_code_t         err_q;

  logic [PA_W-1:0]  rd_addr;
  logic             dec_absent, dec_rsvd, dec_leaf;
  logic [FN_W-1:0]  dec_pfn, dec_next;
  logic [29:0]      dec_mask;
  logic [1:0]       acc_now;
  logic             nx_now, allow;
  logic             need_mark;

  // Named internal events.
  logic ev_start, ev_rsp, ev_absent, ev_rsvd, ev_pass;
  logic ev_denied, ev_leaf_ok, ev_descend, ev_mark, ev_wb_fire;
  logic ev_finish_ok, ev_fault;

  assign rd_addr = {base_q, lvl_index(64'(la_q), lvl_q), 3'b000};

  pw_entry_decode #(.PA_W(PA_W), .EN_1G(EN_1G)) u_decode (
    .i_entry  (i_rsp_data),
    .i_lvl    (lvl_q),
    .i_la_mid (la_q[29:12]),
    .o_absent (dec_absent),
    .o_rsvd   (dec_rsvd),
    .o_leaf   (dec_leaf),
    .o_pfn    (dec_pfn),
    .o_next   (dec_next),
    .o_mask   (dec_mask)
  );

  pw_rights u_rights (
    .i_acc_prev (acc_q),
    .i_ent_us   (i_rsp_data[B_US]),
    .i_ent_rw   (i_rsp_data[B_RW]),
    .i_nx_prev  (nx_q),
    .i_ent_xd   (i_rsp_data[B_XD]),
    .i_fetch    (fetch_q),
    .i_wp       (wp_q),
    .i_user     (user_q),
    .i_write    (wr_q),
    .o_acc      (acc_now),
    .o_nx       (nx_now),
    .o_allow    (allow)
  );

  assign need_mark    = ~i_rsp_data[B_ACC] | (wr_q & ~i_rsp_data[B_DIRTY]);
  assign ev_start     = i_start & (st_q == ST_IDLE);
  assign ev_rsp       = (st_q == ST_RD_WAIT) & i_rsp_valid;
  assign ev_absent    = ev_rsp & dec_absent;
  assign ev_rsvd      = ev_rsp & ~dec_absent & dec_rsvd;
  assign ev_pass      = ev_rsp & ~dec_absent & ~dec_rsvd;
  assign ev_denied    = ev_pass & dec_leaf & ~allow;
  assign ev_leaf_ok   = ev_pass & dec_leaf & allow;
  assign ev_descend   = ev_pass & ~dec_leaf;
  assign ev_mark      = ev_leaf_ok & need_mark;
  assign ev_wb_fire   = (st_q == ST_WB_REQ) & i_req_ready;
  assign ev_finish_ok = (ev_leaf_ok & ~need_mark) | ev_wb_fire;
  assign ev_fault     = ev_absent | ev_rsvd | ev_denied;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      lvl_q     <= '0;
      la_q      <= '0;
      wr_q      <= 1'b0;
      user_q    <= 1'b0;
      wp_q      <= 1'b0;
      fetch_q   <= 1'b0;
      base_q    <= '0;
      acc_q     <= 2'b11;
      nx_q      <= 1'b0;
      wb_data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (ev_start) begin
          st_q    <= ST_RD_REQ;
          lvl_q   <= 2'd3;
          la_q    <= i_laddr;
          wr_q    <= i_write;
          user_q  <= i_user;
          wp_q    <= i_wp;
          fetch_q <= i_fetch;
          base_q  <= i_root;
          acc_q   <= 2'b11;
          nx_q    <= 1'b0;
        end
        ST_RD_REQ: if (i_req_ready) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (ev_rsp) begin
          if (ev_descend) begin
            st_q   <= ST_RD_REQ;
            lvl_q  <= lvl_q - 2'd1;
            base_q <= dec_next;
            acc_q  <= acc_now;
            nx_q   <= nx_now;
          end else if (ev_mark) begin
            st_q      <= ST_WB_REQ;
            wb_data_q <= i_rsp_data | (ENT_W'(1) << B_ACC) | (ENT_W'(wr_q) << B_DIRTY);
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_WB_REQ: if (i_req_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pfn_q   <= '0;
      mask_q  <= '0;
      err_q   <= '0;
    end else begin
      done_q  <= ev_finish_ok;
      fault_q <= ev_fault;
      if (ev_leaf_ok) begin
        pfn_q  <= dec_pfn;
        mask_q <= dec_mask;
      end
      if (ev_fault) err_q <= make_code(ev_rsvd, ev_rsvd | ev_denied, user_q, wr_q);
    end
  end

  assign o_req_valid = (st_q == ST_RD_REQ) | (st_q == ST_WB_REQ);
  assign o_req_write = (st_q == ST_WB_REQ);
  assign o_req_addr  = rd_addr;
  assign o_req_wdata = wb_data_q;
  assign o_done      = done_q;
  assign o_fault     = fault_q;
  assign o_pfn       = pfn_q;
  assign o_mask      = mask_q;
  assign o_err       = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    o_req_valid && !i_req_ready |=> o_req_valid && $stable(o_req_addr) && $stable(o_req_write)); // R12
  AST_NO_REQ_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    o_req_valid && i_req_ready && !o_req_write |=> !o_req_valid); // R12
  AST_TOP_NOT_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp && lvl_q == 2'd3 |-> !ev_leaf_ok); // R4
  AST_RSVD_SETS_P: assert property (@(posedge clk) disable iff (!rst_n)
    o_fault && o_err[3] |-> o_err[0]); // R4
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    o_done |-> (o_mask == 30'hFFF || o_mask == 30'h1F_FFFF || o_mask == 30'h3FFF_FFFF)); // R5
  AST_WB_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    o_req_valid && o_req_write |-> o_req_wdata[B_ACC] && (o_req_wdata[B_DIRTY] || !wr_q)); // R10
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(o_done && o_fault)); // R11
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done || o_fault) |=> !(o_done || o_fault)); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    i_start && st_q != ST_IDLE |=> $stable(la_q) && $stable(wr_q)); // R11

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int LA_W = 48;
  localparam int PA_W = 40;
  localparam int FN_W = PA_W - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LA_W-1:0] laddr = '0;
  logic [FN_W-1:0] root = '0;
  logic write = 1'b0, user = 1'b0, wp = 1'b0, fetch = 1'b0;
  logic req_valid, req_write;
  logic req_ready = 1'b0;
  logic [PA_W-1:0] req_addr;
  logic [63:0] req_wdata;
  logic rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic done, fault;
  logic [FN_W-1:0] pfn;
  logic [29:0] mask;
  logic [3:0] err;

  always #5 clk = ~clk;

  pt_walker #(.LA_W(LA_W), .PA_W(PA_W), .EN_1G(1'b1)) i_pt_walker (
    .clk(clk), .rst_n(rst_n), .i_start(start), .i_laddr(laddr), .i_root(root),
    .i_write(write), .i_user(user), .i_wp(wp), .i_fetch(fetch),
    .o_req_valid(req_valid), .i_req_ready(req_ready), .o_req_write(req_write),
    .o_req_addr(req_addr), .o_req_wdata(req_wdata),
    .i_rsp_valid(rsp_valid), .i_rsp_data(rsp_data),
    .o_done(done), .o_fault(fault), .o_pfn(pfn), .o_mask(mask), .o_err(err)
  );

  logic [63:0] mem [logic [PA_W-1:0]];
  int n_checks = 0;
  int n_errors = 0;
  int rd_cnt = 0;
  int wb_cnt = 0;
  logic [PA_W-1:0] rd_log [8];
  logic [PA_W-1:0] wb_addr;
  logic [63:0] wb_data;

  logic exp_ok, exp_wb;
  logic [FN_W-1:0] exp_pfn;
  logic [29:0] exp_mask;
  logic [3:0] exp_err;
  int exp_reads;
  logic [PA_W-1:0] exp_addr [4];
  logic [PA_W-1:0] exp_wb_addr;
  logic [63:0] exp_wb_data;
  string exp_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Memory responder: random ready, random read latency, logs accesses.
  initial begin
    logic hs_v, hs_w, pend;
    logic [PA_W-1:0] hs_a, pa;
    logic [63:0] hs_d;
    int lat;
    hs_v = 0; hs_w = 0; pend = 0; hs_a = '0; pa = '0; hs_d = '0; lat = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (hs_v && !req_ready && rst_n)
        check(req_valid && req_addr == hs_a && req_write == hs_w, "R12", "request held",
              {23'd0, req_valid, req_addr}, {23'd1, 1'b1, hs_a});
      if (req_ready && hs_v) begin
        if (hs_w) begin
          wb_cnt++; wb_addr = hs_a; wb_data = hs_d; mem[hs_a] = hs_d;
        end else begin
          if (rd_cnt < 8) rd_log[rd_cnt] = hs_a;
          rd_cnt++; pend = 1; pa = hs_a; lat = int'($urandom % 3);
        end
      end
      if (pend) begin
        if (lat == 0) begin
          rsp_valid = 1'b1;
          rsp_data = mem.exists(pa) ? mem[pa] : 64'd0;
          pend = 0;
        end else lat--;
      end
      hs_v = req_valid; hs_a = req_addr; hs_w = req_write; hs_d = req_wdata;
      if (pend && req_valid && !req_write)
        check(1'b0, "R12", "read issued while one pending", 64'd1, 64'd0);
      req_ready = req_valid && !pend && ($urandom % 4 != 0);
    end
  end

  // Reference translation computed from the requirements.
  task automatic ref_walk();
    logic [FN_W-1:0] b;
    logic [1:0] acc;
    logic nx, ps, rs, ok;
    logic [63:0] e;
    logic [PA_W-1:0] a;
    b = root; acc = 2'b11; nx = 0; exp_reads = 0; exp_wb = 0; exp_ok = 0;
    exp_pfn = '0; exp_mask = '0; exp_err = '0;
    for (int l = 3; l >= 0; l--) begin
      a = {b, laddr[12+9*l +: 9], 3'b000};
      exp_addr[exp_reads] = a;
      exp_reads++;
      e = mem.exists(a) ? mem[a] : 64'd0;
      if (!e[0]) begin exp_err = {1'b0, user, write, 1'b0}; exp_tag = "R3"; return; end
      ps = e[7];
      rs = (e[51:PA_W] != 0) || (l == 3 && ps) || (l == 2 && ps && e[29:13] != 0)
           || (l == 1 && ps && e[20:13] != 0);
      if (rs) begin exp_err = {1'b1, user, write, 1'b1}; exp_tag = "R4"; return; end
      acc = acc & {e[2], e[1]};
      nx = nx | (fetch & e[63]);
      if (l == 0 || ps) begin
        if (nx) begin exp_err = {1'b0, user, write, 1'b1}; exp_tag = "R9"; return; end
        ok = user ? (acc[1] && (!write || acc[0])) : (!write || acc[0] || !wp);
        if (!ok) begin exp_err = {1'b0, user, write, 1'b1}; exp_tag = "R8"; return; end
        exp_ok = 1;
        if (l == 2) begin exp_pfn = {e[PA_W-1:30], laddr[29:12]}; exp_mask = 30'h3FFF_FFFF; exp_tag = "R5"; end
        else if (l == 1) begin exp_pfn = {e[PA_W-1:21], laddr[20:12]}; exp_mask = 30'h1F_FFFF; exp_tag = "R6"; end
        else begin exp_pfn = e[PA_W-1:12]; exp_mask = 30'hFFF; exp_tag = "R7"; end
        if (!e[5] || (write && !e[6])) begin
          exp_wb = 1; exp_wb_addr = a;
          exp_wb_data = e | 64'h20 | (write ? 64'h40 : 64'h0);
        end
        return;
      end
      b = e[PA_W-1:12];
    end
  endtask

  task automatic build(input int leaf, input int flaw);
    logic [FN_W-1:0] b;
    logic [63:0] e;
    mem.delete();
    b = FN_W'($urandom);
    root = b;
    laddr = LA_W'({$urandom, $urandom});
    for (int l = 3; l >= leaf; l--) begin
      e = {$urandom, $urandom};
      e[51:PA_W] = '0;
      e[0] = 1'b1;
      e[7] = (l == leaf && l > 0);
      e[2] = ($urandom % 8 != 0);
      e[1] = ($urandom % 8 != 0);
      e[63] = ($urandom % 8 == 0);
      if (l == leaf && l == 2) e[29:13] = '0;
      if (l == leaf && l == 1) e[20:13] = '0;
      if (flaw == 1 && $urandom % 4 == 0) e[0] = 1'b0;
      if (flaw == 2 && $urandom % 4 == 0) e[40 + int'($urandom % 12)] = 1'b1;
      if (flaw == 3 && $urandom % 3 == 0) e[7] = 1'b1;
      if (flaw == 4 && l == leaf && l > 0) e[13 + int'($urandom % 8)] = 1'b1;
      mem[{b, laddr[12+9*l +: 9], 3'b000}] = e;
      b = e[PA_W-1:12];
    end
  endtask

  task automatic run_walk(input bit poke);
    int t;
    bit same;
    ref_walk();
    rd_cnt = 0; wb_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; laddr = ~laddr; write = ~write; user = ~user; root = ~root;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!(done || fault) && t < 400) begin @(negedge clk); t++; end
    check(done == exp_ok && fault == !exp_ok, poke ? "R11" : exp_tag, "outcome",
          {62'd0, done, fault}, {62'd0, exp_ok, !exp_ok});
    if (exp_ok) begin
      check(pfn == exp_pfn, exp_tag, "frame", 64'(pfn), 64'(exp_pfn));
      check(mask == exp_mask, exp_tag, "mask", 64'(mask), 64'(exp_mask));
    end else begin
      check(err == exp_err, exp_tag, "error code", 64'(err), 64'(exp_err));
    end
    @(negedge clk);
    check(!done && !fault, "R11", "one-cycle result", {62'd0, done, fault}, 64'd0);
    same = (rd_cnt == exp_reads);
    for (int k = 0; k < 4; k++) if (same && k < exp_reads && rd_log[k] != exp_addr[k]) same = 0;
    check(same, "R1,R2", "read sequence", 64'(rd_cnt), 64'(exp_reads));
    check(wb_cnt == (exp_wb ? 1 : 0), "R10", "write-back count", 64'(wb_cnt), exp_wb ? 64'd1 : 64'd0);
    if (exp_wb && wb_cnt == 1) begin
      check(wb_addr == exp_wb_addr, "R10", "write-back address", 64'(wb_addr), 64'(exp_wb_addr));
      check(wb_data == exp_wb_data, "R10", "write-back data", wb_data, exp_wb_data);
    end
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    check(!done && !fault && !req_valid, "R11", "reset state",
          {61'd0, done, fault, req_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: clean 4 KB walk with flags already set, write access: no write-back (R10).
    build(0, 0);
    foreach (mem[k]) mem[k] = mem[k] | 64'h66;
    foreach (mem[k]) mem[k][63] = 1'b0;
    write = 1'b1; user = 1'b1; wp = 1'b1; fetch = 1'b0;
    run_walk(0);

    // Directed: second start during a walk is ignored (R11).
    build(1, 0);
    write = 1'b0; user = 1'b0; wp = 1'b0; fetch = 1'b0;
    run_walk(1);

    // Directed: 1 GB page as supervisor read (R5).
    build(2, 0);
    write = 1'b0; user = 1'b0; wp = 1'b0; fetch = 1'b0;
    run_walk(0);

    for (int n = 0; n < 400; n++) begin
      build(int'($urandom % 3), int'($urandom % 5));
      write = $urandom % 2; user = $urandom % 2; wp = $urandom % 2; fetch = ($urandom % 4 == 0);
      run_walk(n % 37 == 5);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule